// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading up to three 64-bit page table entries from memory. It reads one entry per level through a read port that allows one request at a time. The block that uses it latches a request with a one-cycle `start` pulse. The request carries the address, the access kind, the privilege mode and the frame number of the level-1 table. The block then raises `busy` while it fetches. When the translation ends it raises `done` and holds the result until the next `start`.

Before any fetch, a segment decode looks at the top of the implemented address range. An address that is not a proper sign extension of its implemented width fails at once. The segment value 2 is a kernel window that passes the address through unchanged. Every other segment walks the tables. Each fetched entry is checked for its valid bit and its per-mode enables. A walk stops at the first level that fails. The final entry also supplies fault-on-access bits and a page-size granularity hint.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `memReq` are low, and `faultCode`, `physAddr`, `pageShift`, `permRead` and `permWrite` are zero.
- R2: The table index for level L is taken from the virtual address. Level 1 uses bits [PAGE_BITS+2*(PAGE_BITS-3) +: PAGE_BITS-3], level 2 the next field down, and level 3 bits [PAGE_BITS +: PAGE_BITS-3]. The address of each entry is `(base << PAGE_BITS) + 8*index`. The base for level 1 is `tableBase`, and the base for each later level is bits 63:32 of the previous entry.
- R3: An address whose bits [63:VA_BITS-1] are not all equal ends with `faultCode` 1 and issues no memory read.
- R4: When bits [VA_BITS-1:VA_BITS-2] equal 2, no memory read is issued. In kernel mode the result is code 0, with `physAddr` equal to the virtual address, `pageShift` equal to PAGE_BITS and both permission flags set. In user mode the result is code 2.
- R5: At levels 1 and 2, an entry with bit 0 (valid) clear gives code 1. A valid entry with bit 8 (kernel read enable) clear gives code 2. Either outcome ends the walk with no further read.
- R6: At level 3 the enables are selected by mode. User mode (`userMode`=1) uses bit 13 for write and bit 9 for read. Kernel mode uses bit 12 for write and bit 8 for read. The access kind is encoded in `accType` as 0 for read, 1 for write and 2 for execute. A write needs the write enable; a read or an execute needs the read enable. A missing enable gives code 2.
- R7: A permitted level-3 access then checks only the fault-on bit of its own kind. A read checks bit 1 and gives code 3. An execute checks bit 3 and gives code 4. A write checks bit 2 and gives code 5. Otherwise the result is code 0.
- R8: At level 3 the checks apply in a fixed priority: invalid (1) first, then access violation (2), then the fault-on codes.
- R9: On code 0 after a walk, `physAddr` = (bits 63:32 of the final entry << PAGE_BITS) | the low PAGE_BITS bits of the virtual address. `pageShift` = PAGE_BITS + 3*(final entry bits 6:5). `permRead` and `permWrite` show the mode-selected read and write enables.
- R10: On any nonzero code, `physAddr`, `pageShift`, `permRead` and `permWrite` are zero.
- R11: `memReq` is high only while `busy` is high. A request holds its address until `memValid` is seen. `done` stays high, and every result stays stable, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that latches a new request (only while not busy) |
| vaddr | input | 64 | Virtual address to translate |
| accType | input | 2 | 0 read, 1 write, 2 execute |
| userMode | input | 1 | 1 user mode, 0 kernel mode |
| tableBase | input | 64 | Frame number of the level-1 table |
| busy | output | 1 | A walk is fetching entries |
| done | output | 1 | Result is valid and held |
| memReq | output | 1 | Entry read request, held until accepted |
| memAddr | output | 64 | Byte address of the entry being read |
| memValid | input | 1 | Read data valid; completes the pending request |
| memData | input | 64 | Entry read from memory |
| physAddr | output | 64 | Translated physical address |
| pageShift | output | SHIFT_W ($clog2(PAGE_BITS+10), 5 by default) | Log2 of the effective page size |
| permRead | output | 1 | Mode-selected read enable of the final mapping |
| permWrite | output | 1 | Mode-selected write enable of the final mapping |
| faultCode | output | 3 | 0 ok, 1 invalid, 2 access violation, 3/4/5 fault on read/execute/write |

## Verification
The properties assume three things about the inputs. `memValid` is raised only while `memReq` is high. `start` is never pulsed while `busy` is high. `accType` never takes the value 3. The bench drives `start` only when `busy` is low and uses only the three defined access kinds. Its memory responder answers only a pending request, after a chosen delay of zero to three cycles, and drops `memValid` after a single cycle.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_L1,
    W_L2,
    W_L3,
    W_DONE
  } walkState_e;

  localparam logic [2:0] FC_OK      = 3'd0;
  localparam logic [2:0] FC_INVALID = 3'd1;
  localparam logic [2:0] FC_ACCESS  = 3'd2;
  localparam logic [2:0] FC_ON_RD   = 3'd3;
  localparam logic [2:0] FC_ON_EX   = 3'd4;
  localparam logic [2:0] FC_ON_WR   = 3'd5;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam int BIT_VALID  = 0;
  localparam int BIT_FO_RD  = 1;
  localparam int BIT_FO_WR  = 2;
  localparam int BIT_FO_EX  = 3;
  localparam int BIT_K_RD   = 8;
  localparam int BIT_U_RD   = 9;
  localparam int BIT_K_WR   = 12;
  localparam int BIT_U_WR   = 13;
  localparam int GH_LO      = 5;
  localparam int PFN_LO     = 32;

  typedef struct packed {
    logic       capture;
    logic       stepLevel;
    logic       finalize;
    logic [1:0] level;
  } walkStrobe_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
`timescale 1ns/1ps
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memValid,
  input  logic        segWalk,
  input  logic        entryStop,
  output walkStrobe_t strb,
  output logic        busy,
  output logic        done,
  output logic        memReq
);

  walkState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= W_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strb           = '0;
    case (state)
      W_L1:    strb.level = 2'd1;
      W_L2:    strb.level = 2'd2;
      W_L3:    strb.level = 2'd3;
      default: strb.level = 2'd0;
    endcase
    case (state)
      W_IDLE, W_DONE: begin
        if (start) begin
          strb.capture = 1'b1;
          stateNext    = segWalk ? W_L1 : W_DONE;
        end
      end
      W_L1, W_L2, W_L3: begin
        if (memValid) begin
          if (entryStop) begin
            strb.finalize = 1'b1;
            stateNext     = W_DONE;
          end else begin
            strb.stepLevel = 1'b1;
            stateNext      = (state == W_L1) ? W_L2 : W_L3;
          end
        end
      end
      default: stateNext = W_IDLE;
    endcase
  end

  assign busy   = (state == W_L1) || (state == W_L2) || (state == W_L3);
  assign memReq = busy;
  assign done   = (state == W_DONE);

endmodule

// File: rtl/pt_walker_dp.sv
`timescale 1ns/1ps
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int SHIFT_W   = $clog2(PAGE_BITS + 10)
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strb,
  input  logic [63:0]        vaddr,
  input  logic [1:0]         accType,
  input  logic               userMode,
  input  logic [63:0]        tableBase,
  input  logic [63:0]        memData,
  output logic               segWalk,
  output logic               entryStop,
  output logic [63:0]        memAddr,
  output logic [63:0]        physAddr,
  output logic [SHIFT_W-1:0] pageShift,
  output logic               permRead,
  output logic               permWrite,
  output logic [2:0]         faultCode
);

  localparam int LVL_BITS = PAGE_BITS - 3;
  localparam int LEVELS   = 3;
  localparam logic [63:0] OFF_MASK = (64'd1 << PAGE_BITS) - 64'd1;

  logic [63:0] vaReg, baseReg;
  logic [1:0]  accReg;
  logic        userReg;

  // segment decode on the live request
  logic       canonical;
  logic [1:0] segSel;
  logic [2:0] directCode;
  assign canonical  = (&vaddr[63:VA_BITS-1]) || !(|vaddr[63:VA_BITS-1]);
  assign segSel     = vaddr[VA_BITS-1 -: 2];
  assign segWalk    = canonical && (segSel != 2'd2);
  assign directCode = !canonical ? FC_INVALID : (userMode ? FC_ACCESS : FC_OK);

  // per-level table indices, level 1 most significant
  logic [LVL_BITS-1:0] lvlIdx [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : gIdx
    assign lvlIdx[g] = vaReg[PAGE_BITS + (LEVELS-1-g)*LVL_BITS +: LVL_BITS];
  end

  logic [LVL_BITS-1:0] curIdx;
  always_comb begin
    case (strb.level)
      2'd2:    curIdx = lvlIdx[1];
      2'd3:    curIdx = lvlIdx[2];
      default: curIdx = lvlIdx[0];
    endcase
  end
  assign memAddr = (baseReg << PAGE_BITS) + {{(64-LVL_BITS-3){1'b0}}, curIdx, 3'b000};

  // entry evaluation
  logic       isFinal, rdEn, wrEn;
  logic [2:0] entryCode;
  assign isFinal = (strb.level == 2'd3);
  assign rdEn    = userReg ? memData[BIT_U_RD] : memData[BIT_K_RD];
  assign wrEn    = userReg ? memData[BIT_U_WR] : memData[BIT_K_WR];

  always_comb begin
    entryCode = FC_OK;
    if (!memData[BIT_VALID]) begin
      entryCode = FC_INVALID;
    end else if (!isFinal) begin
      if (!memData[BIT_K_RD]) entryCode = FC_ACCESS;
    end else if ((accReg == ACC_WR) ? !wrEn : !rdEn) begin
      entryCode = FC_ACCESS;
    end else if (accReg == ACC_RD && memData[BIT_FO_RD]) begin
      entryCode = FC_ON_RD;
    end else if (accReg == ACC_EX && memData[BIT_FO_EX]) begin
      entryCode = FC_ON_EX;
    end else if (accReg == ACC_WR && memData[BIT_FO_WR]) begin
      entryCode = FC_ON_WR;
    end
  end
  assign entryStop = (entryCode != FC_OK) || isFinal;

  logic [63:0]        pfnExt;
  logic [SHIFT_W-1:0] finalShift;
  assign pfnExt     = {32'd0, memData[63:PFN_LO]};
  assign finalShift = SHIFT_W'(PAGE_BITS + 3 * int'(memData[GH_LO +: 2]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg     <= '0;
      baseReg   <= '0;
      accReg    <= '0;
      userReg   <= 1'b0;
      physAddr  <= '0;
      pageShift <= '0;
      permRead  <= 1'b0;
      permWrite <= 1'b0;
      faultCode <= FC_OK;
    end else if (strb.capture) begin
      vaReg     <= vaddr;
      baseReg   <= tableBase;
      accReg    <= accType;
      userReg   <= userMode;
      physAddr  <= '0;
      pageShift <= '0;
      permRead  <= 1'b0;
      permWrite <= 1'b0;
      faultCode <= FC_OK;
      if (!segWalk) begin
        faultCode <= directCode;
        if (directCode == FC_OK) begin
          physAddr  <= vaddr;
          pageShift <= SHIFT_W'(PAGE_BITS);
          permRead  <= 1'b1;
          permWrite <= 1'b1;
        end
      end
    end else if (strb.stepLevel) begin
      baseReg <= pfnExt;
    end else if (strb.finalize) begin
      faultCode <= entryCode;
      if (entryCode == FC_OK) begin
        physAddr  <= (pfnExt << PAGE_BITS) | (vaReg & OFF_MASK);
        pageShift <= finalShift;
        permRead  <= rdEn;
        permWrite <= wrEn;
      end
    end
  end

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_BITS   = 43,
  parameter int PAGE_BITS = 13,
  parameter int SHIFT_W   = $clog2(PAGE_BITS + 10)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [63:0]        vaddr,
  input  logic [1:0]         accType,
  input  logic               userMode,
  input  logic [63:0]        tableBase,
  output logic               busy,
  output logic               done,
  output logic               memReq,
  output logic [63:0]        memAddr,
  input  logic               memValid,
  input  logic [63:0]        memData,
  output logic [63:0]        physAddr,
  output logic [SHIFT_W-1:0] pageShift,
  output logic               permRead,
  output logic               permWrite,
  output logic [2:0]         faultCode
);

  walkStrobe_t strb;
  logic        segWalk, entryStop;

  pt_walker_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memValid  (memValid),
    .segWalk   (segWalk),
    .entryStop (entryStop),
    .strb      (strb),
    .busy      (busy),
    .done      (done),
    .memReq    (memReq)
  );

  pt_walker_dp #(
    .VA_BITS   (VA_BITS),
    .PAGE_BITS (PAGE_BITS),
    .SHIFT_W   (SHIFT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .vaddr     (vaddr),
    .accType   (accType),
    .userMode  (userMode),
    .tableBase (tableBase),
    .memData   (memData),
    .segWalk   (segWalk),
    .entryStop (entryStop),
    .memAddr   (memAddr),
    .physAddr  (physAddr),
    .pageShift (pageShift),
    .permRead  (permRead),
    .permWrite (permWrite),
    .faultCode (faultCode)
  );

endmodule

// File: rtl/pt_walker_checker.sv
`timescale 1ns/1ps
module pt_walker_checker #(
  parameter int PAGE_BITS = 13,
  parameter int SHIFT_W   = $clog2(PAGE_BITS + 10)
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [1:0]         accType,
  input logic               busy,
  input logic               done,
  input logic               memReq,
  input logic [63:0]        memAddr,
  input logic               memValid,
  input logic [63:0]        physAddr,
  input logic [SHIFT_W-1:0] pageShift,
  input logic               permRead,
  input logic               permWrite,
  input logic [2:0]         faultCode
);

  // input assumptions
  a_r11_valid_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memReq);
  a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);
  a_r6_acc_legal: assert property (@(posedge clk) disable iff (!rstN)
    start |-> accType != 2'd3);

  // behaviour
  a_r11_req_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy && !done);
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));
  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(physAddr) && $stable(faultCode)
      && $stable(pageShift) && $stable(permRead) && $stable(permWrite));
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    done && faultCode != 3'd0 |-> physAddr == 64'd0 && pageShift == '0
      && !permRead && !permWrite);
  a_r9_shift_grain: assert property (@(posedge clk) disable iff (!rstN)
    done && faultCode == 3'd0 |-> (int'(pageShift) >= PAGE_BITS)
      && (int'(pageShift) <= PAGE_BITS + 9)
      && ((int'(pageShift) - PAGE_BITS) % 3 == 0));
  a_r8_code_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> faultCode <= 3'd5);

endmodule

bind pt_walker pt_walker_checker #(
  .PAGE_BITS (PAGE_BITS),
  .SHIFT_W   (SHIFT_W)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .accType   (accType),
  .busy      (busy),
  .done      (done),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memValid  (memValid),
  .physAddr  (physAddr),
  .pageShift (pageShift),
  .permRead  (permRead),
  .permWrite (permWrite),
  .faultCode (faultCode)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

  localparam int VA  = 43;
  localparam int PB  = 13;
  localparam int SW  = $clog2(PB + 10);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   vaddr = '0;
  logic [1:0]    accType = '0;
  logic          userMode = 1'b0;
  logic [63:0]   tableBase = '0;
  logic          busy, done, memReq;
  logic [63:0]   memAddr;
  logic          memValid = 1'b0;
  logic [63:0]   memData = '0;
  logic [63:0]   physAddr;
  logic [SW-1:0] pageShift;
  logic          permRead, permWrite;
  logic [2:0]    faultCode;

  pt_walker #(.VA_BITS(VA), .PAGE_BITS(PB)) uut (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr), .accType(accType),
    .userMode(userMode), .tableBase(tableBase), .busy(busy), .done(done),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .physAddr(physAddr), .pageShift(pageShift), .permRead(permRead),
    .permWrite(permWrite), .faultCode(faultCode)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFails  = 0;
  int latency = 0;
  int waitCnt = 0;
  int reads   = 0;
  int cycles  = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] expAddr [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder, compared against the model's address list every request
  always @(negedge clk) begin
    if (memValid) begin
      memValid = 1'b0;
    end else if (memReq) begin
      if (waitCnt >= latency) begin
        reads++;
        if (expAddr.size() == 0) begin
          check(1'b0, "R5 extra read", memAddr, 64'd0);
        end else begin
          logic [63:0] e;
          e = expAddr.pop_front();
          check(memAddr == e, "R2 entry address", memAddr, e);
        end
        memData  = mem.exists(memAddr) ? mem[memAddr] : 64'd0;
        memValid = 1'b1;
        waitCnt  = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nChecks++; nFails++;
      $display("FAIL R11 watchdog actual=%0d expected=0", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  // behavioural reference translation
  task automatic model(input logic [63:0] va, input int acc, input bit usr,
                       input logic [63:0] tb, output int code,
                       output logic [63:0] pa, output int shift,
                       output bit pr, output bit pw);
    logic [63:0] ext, base, a, e;
    int seg;
    code = 0; pa = 0; shift = 0; pr = 0; pw = 0;
    ext = 64'($signed(va << (64 - VA)) >>> (64 - VA));
    seg = int'((va >> (VA - 2)) & 64'd3);
    if (ext != va) begin code = 1; return; end
    if (seg == 2) begin
      if (usr) code = 2;
      else begin pa = va; shift = PB; pr = 1; pw = 1; end
      return;
    end
    base = tb;
    for (int lv = 1; lv <= 3; lv++) begin
      a = (base * 64'd8192) + ((va >> (PB + 10 * (3 - lv))) & 64'd1023) * 64'd8;
      expAddr.push_back(a);
      e = mem.exists(a) ? mem[a] : 64'd0;
      if (e[0] == 1'b0) begin code = 1; return; end
      if (lv < 3) begin
        if (e[8] == 1'b0) begin code = 2; return; end
        base = e >> 32;
      end else begin
        bit r, w;
        r = usr ? e[9] : e[8];
        w = usr ? e[13] : e[12];
        if ((acc == 1) ? !w : !r) begin code = 2; return; end
        if (acc == 0 && e[1]) code = 3;
        else if (acc == 2 && e[3]) code = 4;
        else if (acc == 1 && e[2]) code = 5;
        if (code == 0) begin
          pa = ((e >> 32) << PB) | (va & 64'h1FFF);
          shift = PB + 3 * int'(e[6:5]);
          pr = r; pw = w;
        end
      end
    end
  endtask

  task automatic runCase(input string tag, input logic [63:0] va, input int acc,
                         input bit usr, input int lat);
    int code, shift, exReads, guard;
    logic [63:0] pa, pa0;
    bit pr, pw;
    expAddr.delete();
    model(va, acc, usr, 64'h100, code, pa, shift, pr, pw);
    exReads = expAddr.size();
    latency = lat; reads = 0; waitCnt = 0;
    @(negedge clk);
    vaddr = va; accType = 2'(acc); userMode = usr; tableBase = 64'h100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin
      check(busy, {tag, " R11 busy during walk"}, 64'(busy), 64'd1);
      @(negedge clk);
      guard++;
    end
    check(done, {tag, " R11 done reached"}, 64'(done), 64'd1);
    check(faultCode == 3'(code), {tag, " code"}, 64'(faultCode), 64'(code));
    check(reads == exReads, {tag, " R5 read count"}, 64'(reads), 64'(exReads));
    check(physAddr == pa, {tag, " R9/R10 physAddr"}, physAddr, pa);
    check(int'(pageShift) == shift && permRead == pr && permWrite == pw,
          {tag, " R9/R10 shift+perms"}, {pageShift, permRead, permWrite},
          {SW'(shift), pr, pw});
    pa0 = physAddr;
    repeat (2) @(negedge clk);
    check(done && physAddr == pa0 && faultCode == 3'(code) && !memReq,
          {tag, " R11 result held"}, physAddr, pa0);
  endtask

  localparam logic [63:0] F_V = 64'h1, F_FR = 64'h2, F_FW = 64'h4, F_FE = 64'h8;
  localparam logic [63:0] F_KR = 64'h100, F_UR = 64'h200, F_KW = 64'h1000, F_UW = 64'h2000;
  localparam logic [63:0] VA_A = (64'd1 << 33) | (64'd2 << 23) | (64'd3 << 13) | 64'h123;
  localparam logic [63:0] VA_NEG = 64'hFFFF_FE00_0000_0000 | (64'd2 << 23) | (64'd3 << 13) | 64'h55;
  localparam logic [63:0] L3A = 64'h60_0018;

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !memReq && faultCode == 0 && physAddr == 0
          && pageShift == 0 && !permRead && !permWrite, "R1 reset state",
          {busy, done, memReq, faultCode}, 64'd0);
    rstN = 1'b1;
    mem[64'h20_0008] = (64'h200 << 32) | F_V | F_KR;
    mem[64'h20_1800] = (64'h200 << 32) | F_V | F_KR;
    mem[64'h40_0010] = (64'h300 << 32) | F_V | F_KR;

    mem[L3A] = (64'h4567 << 32) | F_V | F_UR;
    runCase("R2 R9 user read", VA_A, 0, 1, 0);
    mem[L3A] = (64'h4567 << 32) | F_V | F_KR | F_KW | (64'd3 << 5);
    runCase("R9 kernel write gh3", VA_A, 1, 0, 2);
    mem[L3A] = (64'h4567 << 32) | F_V | F_UR;
    runCase("R6 user write denied", VA_A, 1, 1, 1);
    mem[L3A] = (64'h4567 << 32) | F_V | F_KR | F_FE;
    runCase("R7 fault on execute", VA_A, 2, 0, 3);
    mem[L3A] = (64'h4567 << 32) | F_V | F_UR | F_FR;
    runCase("R7 fault on read", VA_A, 0, 1, 0);
    mem[L3A] = (64'h4567 << 32) | F_V | F_KW | F_FW;
    runCase("R7 fault on write", VA_A, 1, 0, 1);
    mem[L3A] = (64'h4567 << 32) | F_V | F_KR | F_FW | F_FE | (64'd1 << 5);
    runCase("R7 other fault bits ignored", VA_A, 0, 0, 2);
    mem[L3A] = (64'h4567 << 32) | F_V | F_KR | F_FE;
    runCase("R8 violation beats fault-on", VA_A, 2, 1, 0);
    mem[L3A] = (64'h4567 << 32) | F_UR | F_FR;
    runCase("R8 invalid first", VA_A, 0, 1, 1);
    mem[L3A] = (64'h4567 << 32) | F_V | F_KR;
    runCase("R2 R3 sign-extended walk", VA_NEG, 0, 0, 1);
    mem[64'h40_0010] = (64'h300 << 32) | F_V | F_UR;
    runCase("R5 level2 no kernel read", VA_A, 0, 1, 2);
    mem[64'h20_0008] = 64'd0;
    runCase("R5 level1 invalid", VA_A, 0, 0, 0);
    runCase("R3 non-canonical", 64'h0000_0400_0000_0000, 0, 0, 0);
    runCase("R4 direct kernel", 64'hFFFF_FC00_0000_1234, 1, 0, 0);
    runCase("R4 direct user", 64'hFFFF_FC00_0000_1234, 0, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule